// File: doc/BRIEF.md
# Triple Frame Buffer Pointer Controller

This block decides which of three frame regions in external memory the video writer and the video reader use. One region is filled by the incoming video, one is scanned out by the outgoing video, and the third holds a finished frame waiting to be shown. The reader therefore never scans a frame that is still being written, and the displayed picture does not tear. The block rotates the slot indices at frame boundaries and turns each index into a base address that the burst engines add to their line offsets.

Each side reports a new frame as the falling edge of its active-low vertical sync. Both sync inputs are already synchronous to the block clock. At a write frame start, the frame just filled becomes the newest complete frame and the writer moves to the spare slot. At a read frame start, the reader takes the newest complete frame if one is waiting. Otherwise it shows its current frame again. Either side can be frozen with a halt input. When rotation is switched off, both sides share one region.

Top module: `tfb_ptr_ctrl`

## Requirements
- R1: Reset is synchronous and active low. While it is asserted and after it is released, the write slot is 0, the read slot is 2, the spare slot is 1 and no completed frame is pending.
- R2: Each base output equals its slot index times FRAME_SPAN, truncated to ADDR_W bits. The defaults are FRAME_SPAN = 0x0080_0000 and ADDR_W = 28, so slot 0 maps to 0x0000000, slot 1 to 0x0800000 and slot 2 to 0x1000000.
- R3: A frame start is a sampled cycle in which the sync input is low after it was high in the previous sampled cycle. Holding the sync low for several cycles counts as one frame start. A slot change caused by a frame start is visible on the outputs right after that clock edge.
- R4: At a write frame start, the slot being written becomes the pending completed frame and the writer moves to the spare slot.
- R5: At a read frame start with a completed frame pending, the reader moves to that frame's slot, and the slot the reader leaves becomes the spare.
- R6: At a read frame start with no completed frame pending, the read slot does not change.
- R7: When write and read frame starts fall in the same cycle, the reader takes the slot that was just written, the writer takes the spare slot, and the slot the reader leaves becomes the spare.
- R8: While wr_halt is 1, write frame starts have no effect. While rd_halt is 1, read frame starts have no effect.
- R9: In rotating mode the write slot and the read slot always differ, and neither changes except at its own side's frame start or at a simultaneous frame start.
- R10: While rotate_en is 0, both slot outputs are 0 and both bases are 0 from the next edge on. Frame starts and halts are ignored, and the internal rotation state is kept, so rotation resumes from the same slots when rotate_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; both syncs are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| rotate_en | input | 1 | 1: three-slot rotation; 0: one shared region at base 0 |
| wr_vs_n | input | 1 | Active-low vertical sync of the incoming video |
| wr_halt | input | 1 | 1: ignore write frame starts |
| rd_vs_n | input | 1 | Active-low vertical sync of the outgoing video |
| rd_halt | input | 1 | 1: ignore read frame starts |
| wr_slot | output | 2 | Slot index being written |
| rd_slot | output | 2 | Slot index being read |
| wr_base | output | ADDR_W | Base address of the frame being written |
| rd_base | output | ADDR_W | Base address of the frame being read |

## Verification
The main stimulus table drives lone write frame starts, lone read frame starts with and without a pending frame, and simultaneous frame starts. It repeats some of these with one halt or the other raised. The lone starts show whether the writer and reader swap with the spare slot, not with each other. The simultaneous cases, with each halt tried separately, show whether the reader takes the frame that just finished and whether a halt blocks only its own side. A stretch with rotation disabled, followed by a quiet frame with rotation enabled again, shows that shared mode forces base 0 without losing the slot state. Directed cases follow. One holds a sync low for several cycles to separate edge detection from level detection. Another waits through a long quiet frame to catch any pointer that drifts in mid-frame.

// File: rtl/tfb_pkg.sv
// Shared types and constants for the triple frame buffer pointer controller.
// Assumes slot indices 0..2. Index 3 is never produced and maps to base 0.
package tfb_pkg;

    localparam int NUM_SLOTS = 3;
    localparam int SLOT_W    = 2;

    typedef logic [SLOT_W-1:0] slot_t;

    // Slot assignment left by reset.
    localparam slot_t RST_WR_SLOT    = 2'd0;
    localparam slot_t RST_RD_SLOT    = 2'd2;
    localparam slot_t RST_SPARE_SLOT = 2'd1;

endpackage

// File: rtl/tfb_vs_fall.sv
// Frame-start detector: flags the cycle in which an active-low vsync is first
// seen low. Assumes vs_n is already synchronous to clk. The stored level resets
// high, so a sync held low yields one pulse and no pulse repeats.
module tfb_vs_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_n,
    output logic start
);

    logic vs_q;

    // Remember the previous sampled level of the sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q <= 1'b1;
        end else begin
            vs_q <= vs_n;
        end
    end

    assign start = vs_q & ~vs_n;

endmodule

// File: rtl/tfb_slot_rotator.sv
// Slot rotation core: holds the write, read and spare slot indices plus a flag
// that marks the spare as a completed, unshown frame. Produces next-state
// values so the base registers update on the same edge as the state.
// Assumes the step inputs are already gated by mode and halt.
module tfb_slot_rotator
    import tfb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_step,
    input  logic  rd_step,
    output slot_t wr_nxt,
    output slot_t rd_nxt
);

    slot_t wr_q, rd_q, spare_q;
    slot_t spare_nxt;
    logic  fresh_q, fresh_nxt;

    // Compute the rotation for this cycle's frame starts.
    always_comb begin
        wr_nxt    = wr_q;
        rd_nxt    = rd_q;
        spare_nxt = spare_q;
        fresh_nxt = fresh_q;
        unique case ({wr_step, rd_step})
            2'b10: begin
                wr_nxt    = spare_q;
                spare_nxt = wr_q;
                fresh_nxt = 1'b1;
            end
            2'b01: begin
                if (fresh_q) begin
                    rd_nxt    = spare_q;
                    spare_nxt = rd_q;
                    fresh_nxt = 1'b0;
                end
            end
            2'b11: begin
                rd_nxt    = wr_q;
                wr_nxt    = spare_q;
                spare_nxt = rd_q;
                fresh_nxt = 1'b0;
            end
            default: begin
            end
        endcase
    end

    // Hold the slot assignment between frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= RST_WR_SLOT;
            rd_q    <= RST_RD_SLOT;
            spare_q <= RST_SPARE_SLOT;
            fresh_q <= 1'b0;
        end else begin
            wr_q    <= wr_nxt;
            rd_q    <= rd_nxt;
            spare_q <= spare_nxt;
            fresh_q <= fresh_nxt;
        end
    end

endmodule

// File: rtl/tfb_base_reg.sv
// Base address register for one pointer: maps a slot index to its frame base
// through a table built at elaboration time and registers both. When
// rotation is off it registers slot 0 and base 0. Assumes ADDR_W <= 64.
module tfb_base_reg
    import tfb_pkg::*;
#(
    parameter int          ADDR_W     = 28,
    parameter int unsigned FRAME_SPAN = 32'h0080_0000,
    parameter slot_t       RST_SLOT   = 2'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  slot_t             slot_nxt,
    output slot_t             slot_q,
    output logic [ADDR_W-1:0] base_q
);

    localparam int TBL_N = 1 << SLOT_W;

    logic [ADDR_W-1:0] base_tbl [TBL_N];

    // One table entry per slot index; unused indices map to zero.
    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        localparam logic [63:0] PROD = (g < NUM_SLOTS) ?
                                       64'(g) * 64'(FRAME_SPAN) : 64'd0;
        assign base_tbl[g] = PROD[ADDR_W-1:0];
    end

    // Register the selected slot and its base address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= RST_SLOT;
            base_q <= base_tbl[RST_SLOT];
        end else if (active) begin
            slot_q <= slot_nxt;
            base_q <= base_tbl[slot_nxt];
        end else begin
            slot_q <= '0;
            base_q <= '0;
        end
    end

endmodule

// File: rtl/tfb_ptr_ctrl.sv
// Triple frame buffer pointer controller (top). Detects write and read frame
// starts, gates them with the mode and halt inputs, rotates the three slots and
// presents registered slot indices and base addresses. Assumes both syncs are
// synchronous to clk.
module tfb_ptr_ctrl
    import tfb_pkg::*;
#(
    parameter int          ADDR_W     = 28,
    parameter int unsigned FRAME_SPAN = 32'h0080_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rotate_en,
    input  logic              wr_vs_n,
    input  logic              wr_halt,
    input  logic              rd_vs_n,
    input  logic              rd_halt,
    output logic [1:0]        wr_slot,
    output logic [1:0]        rd_slot,
    output logic [ADDR_W-1:0] wr_base,
    output logic [ADDR_W-1:0] rd_base
);

    logic  wr_start, rd_start;
    logic  wr_step, rd_step;
    slot_t wr_nxt, rd_nxt;
    slot_t wr_slot_q, rd_slot_q;

    tfb_vs_fall u_wr_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .vs_n  (wr_vs_n),
        .start (wr_start)
    );

    tfb_vs_fall u_rd_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .vs_n  (rd_vs_n),
        .start (rd_start)
    );

    // Frame starts move a pointer only when rotating and not frozen.
    assign wr_step = wr_start & rotate_en & ~wr_halt;
    assign rd_step = rd_start & rotate_en & ~rd_halt;

    tfb_slot_rotator u_rot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_step (wr_step),
        .rd_step (rd_step),
        .wr_nxt  (wr_nxt),
        .rd_nxt  (rd_nxt)
    );

    tfb_base_reg #(
        .ADDR_W     (ADDR_W),
        .FRAME_SPAN (FRAME_SPAN),
        .RST_SLOT   (RST_WR_SLOT)
    ) u_wr_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (rotate_en),
        .slot_nxt (wr_nxt),
        .slot_q   (wr_slot_q),
        .base_q   (wr_base)
    );

    tfb_base_reg #(
        .ADDR_W     (ADDR_W),
        .FRAME_SPAN (FRAME_SPAN),
        .RST_SLOT   (RST_RD_SLOT)
    ) u_rd_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (rotate_en),
        .slot_nxt (rd_nxt),
        .slot_q   (rd_slot_q),
        .base_q   (rd_base)
    );

    assign wr_slot = wr_slot_q;
    assign rd_slot = rd_slot_q;

endmodule

// File: rtl/tfb_ptr_ctrl_chk.sv
// Checker for the pointer controller, bound to the top. It keeps its own copy
// of the sync levels so frame starts are judged independently of the design.
module tfb_ptr_ctrl_chk #(
    parameter int          ADDR_W     = 28,
    parameter int unsigned FRAME_SPAN = 32'h0080_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rotate_en,
    input logic              wr_vs_n,
    input logic              wr_halt,
    input logic              rd_vs_n,
    input logic              rd_halt,
    input logic [1:0]        wr_slot,
    input logic [1:0]        rd_slot,
    input logic [ADDR_W-1:0] wr_base,
    input logic [ADDR_W-1:0] rd_base
);

    logic wr_lvl_q, rd_lvl_q;

    // Track the previous sync levels for independent edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_lvl_q <= 1'b1;
            rd_lvl_q <= 1'b1;
        end else begin
            wr_lvl_q <= wr_vs_n;
            rd_lvl_q <= rd_vs_n;
        end
    end

    logic wr_edge, rd_edge;
    assign wr_edge = wr_lvl_q & ~wr_vs_n;
    assign rd_edge = rd_lvl_q & ~rd_vs_n;

    p_slot_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_slot != 2'd3) && (rd_slot != 2'd3));

    p_slots_differ_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rotate_en) |-> (wr_slot != rd_slot));

    p_wr_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate_en && $past(rotate_en) && wr_halt) |=> $stable(wr_slot));

    p_rd_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate_en && $past(rotate_en) && rd_halt) |=> $stable(rd_slot));

    p_wr_midframe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate_en && $past(rotate_en) && !wr_edge) |=> $stable(wr_slot));

    p_rd_midframe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate_en && $past(rotate_en) && !rd_edge && !(wr_edge && !wr_halt))
        |=> $stable(rd_slot));

    p_handover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate_en && $past(rotate_en) && wr_edge && !wr_halt && rd_edge && !rd_halt)
        |=> (rd_slot == $past(wr_slot)));

    p_shared_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rotate_en |=> (wr_base == '0 && rd_base == '0 && wr_slot == 2'd0 && rd_slot == 2'd0));

endmodule

bind tfb_ptr_ctrl tfb_ptr_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .FRAME_SPAN (FRAME_SPAN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rotate_en (rotate_en),
    .wr_vs_n   (wr_vs_n),
    .wr_halt   (wr_halt),
    .rd_vs_n   (rd_vs_n),
    .rd_halt   (rd_halt),
    .wr_slot   (wr_slot),
    .rd_slot   (rd_slot),
    .wr_base   (wr_base),
    .rd_base   (rd_base)
);

// File: tb/tfb_ptr_ctrl_test.sv
`timescale 1ns/1ps
module tfb_ptr_ctrl_test;

    localparam int          ADDR_W = 28;
    localparam int unsigned SPAN   = 32'h0080_0000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rotate_en;
    logic              wr_vs_n, wr_halt, rd_vs_n, rd_halt;
    logic [1:0]        wr_slot, rd_slot;
    logic [ADDR_W-1:0] wr_base, rd_base;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    tfb_ptr_ctrl #(.ADDR_W(ADDR_W), .FRAME_SPAN(SPAN)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rotate_en (rotate_en),
        .wr_vs_n   (wr_vs_n),
        .wr_halt   (wr_halt),
        .rd_vs_n   (rd_vs_n),
        .rd_halt   (rd_halt),
        .wr_slot   (wr_slot),
        .rd_slot   (rd_slot),
        .wr_base   (wr_base),
        .rd_base   (rd_base)
    );

    // Vector fields: [8] write start, [7] wr_halt, [6] read start, [5] rd_halt,
    // [4] rotate_en, [3:2] expected write slot, [1:0] expected read slot.
    localparam int NV = 16;
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd2},  // R4
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 2'd0},  // R5
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 2'd0},  // R6
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0},  // R4
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0},  // R4
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 2'd1},  // R7
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd1},  // R8
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1},  // R4
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 2'd1},  // R8
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd2},  // R5
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},  // R10
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0},  // R10
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd2},  // R10 resume
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 2'd2},  // R8
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 2'd0},  // R8
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 2'd1}   // R7
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 3, 4, 7: return "R4";
            1, 9:       return "R5";
            2:          return "R6";
            5, 15:      return "R7";
            6, 8:       return "R8";
            13, 14:     return "R8";
            default:    return "R10";
        endcase
    endfunction

    // Compare slots (requirement tag) and bases (R2) with expected values.
    task automatic check(input logic [1:0] ew, input logic [1:0] er, input string tag);
        logic [ADDR_W-1:0] ewb, erb;
        bit bad;
        ewb = ADDR_W'(ew) * ADDR_W'(SPAN);
        erb = ADDR_W'(er) * ADDR_W'(SPAN);
        bad = 1'b0;
        n_chk++;
        if (wr_slot !== ew) begin
            $display("FAIL %s wr_slot actual %0d expected %0d", tag, wr_slot, ew);
            bad = 1'b1;
        end
        if (rd_slot !== er) begin
            $display("FAIL %s rd_slot actual %0d expected %0d", tag, rd_slot, er);
            bad = 1'b1;
        end
        if (wr_base !== ewb) begin
            $display("FAIL R2 (%s) wr_base actual %h expected %h", tag, wr_base, ewb);
            bad = 1'b1;
        end
        if (rd_base !== erb) begin
            $display("FAIL R2 (%s) rd_base actual %h expected %h", tag, rd_base, erb);
            bad = 1'b1;
        end
        if (bad) n_fail++;
    endtask

    task automatic idle_inputs(input logic rot);
        wr_vs_n   = 1'b1;
        rd_vs_n   = 1'b1;
        wr_halt   = 1'b0;
        rd_halt   = 1'b0;
        rotate_en = rot;
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs(1'b1);
        repeat (3) @(negedge clk);
        check(2'd0, 2'd2, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(2'd0, 2'd2, "R1 after reset");

        // Stimulus table: event cycle, check, then one quiet cycle.
        for (int i = 0; i < NV; i++) begin
            wr_vs_n   = ~VEC[i][8];
            wr_halt   =  VEC[i][7];
            rd_vs_n   = ~VEC[i][6];
            rd_halt   =  VEC[i][5];
            rotate_en =  VEC[i][4];
            @(negedge clk);
            check(VEC[i][3:2], VEC[i][1:0], vec_tag(i));
            idle_inputs(VEC[i][4]);
            @(negedge clk);
        end

        // R1: reset in the middle of operation restores the initial slots.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(2'd0, 2'd2, "R1 mid-run reset");

        // R3: a sync held low steps the writer once only.
        wr_vs_n = 1'b0;
        @(negedge clk);
        check(2'd1, 2'd2, "R3 first low cycle");
        repeat (4) @(negedge clk);
        check(2'd1, 2'd2, "R3 held low");
        wr_vs_n = 1'b1;

        // R9: a long quiet frame moves neither pointer.
        repeat (50) @(negedge clk);
        check(2'd1, 2'd2, "R9 mid-frame");

        // R5: reader picks up the frame completed above.
        rd_vs_n = 1'b0;
        @(negedge clk);
        check(2'd1, 2'd0, "R5 after held write");
        rd_vs_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog finished actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule